// File: doc/BRIEF.md
# Keypad PIN Checker with Retry Limit

The block takes a PIN typed on a small keypad one binary digit at a time and compares it with the PIN read from the inserted card. Two digit keys (0 and 1) shift bits into an entry register, a clear key empties that register, and an enter key compares the entry against the card PIN. A match gives a one-cycle match pulse. A mismatch increments a saturating failure counter. Below the limit a one-cycle retry pulse asks for re-entry. The mismatch that reaches the limit (three by default) raises a lockout level instead.

The surrounding controller raises the enable while it expects a PIN, presents each key with a one-cycle strobe and a one-hot key vector, and pulses the new-card input when a fresh card is inserted. That pulse clears the failure history, the lockout and the entry.

Top module: `pin_checker`

## Requirements
- R1: After reset `match_o`, `retry_o` and `lockout_o` are low and the entry register holds zero.
- R2: A digit key shifts its bit into the entry register at the right (LSB) end, and earlier bits move one place left. A short entry therefore compares as if padded with leading zeros.
- R3: `key_i` is decoded as bit 0 = digit 0, bit 1 = digit 1, bit 2 = clear, bit 3 = enter. A strobe with no key bit set or with more than one bit set is ignored, and so is a key vector presented without a strobe.
- R4: The clear key sets the entry register to zero.
- R5: An enter whose entry equals `card_pin_i` gives `match_o` high for exactly the one cycle after the strobe edge.
- R6: An enter whose entry differs from `card_pin_i`, while fewer than FAIL_LIMIT-1 earlier failures are recorded, gives `retry_o` high for one cycle after the strobe edge, and `lockout_o` stays low.
- R7: The mismatch that brings the failure count to FAIL_LIMIT (3) sets `lockout_o` in the cycle after its strobe edge, with no retry pulse. `lockout_o` then holds until a new card arrives.
- R8: While `lockout_o` is high, every key is ignored, and no match or retry pulse appears even for the correct PIN.
- R9: Every accepted enter clears the entry register, so the next attempt starts from zero.
- R10: `new_card_i` high at a clock edge clears the failure count, the lockout and the entry register, and any key in that cycle is ignored.
- R11: With `pin_en_i` low, all keys are ignored.
- R12: `match_o` and `retry_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_card_i | input | 1 | Card inserted: clears failures, lockout and entry |
| pin_en_i | input | 1 | PIN entry allowed |
| key_stb_i | input | 1 | Key strobe, one cycle per key press |
| key_i | input | 4 | One-hot key: [0] digit 0, [1] digit 1, [2] clear, [3] enter |
| card_pin_i | input | PIN_W (4) | PIN read from the card |
| match_o | output | 1 | One-cycle pulse on a correct PIN |
| retry_o | output | 1 | One-cycle pulse on a wrong PIN below the limit |
| lockout_o | output | 1 | Level, high once the failure limit is reached |

## Verification
A wrong entry register shows up only when an enter is made. It then appears one cycle later as a match pulse where a retry was due, or the reverse. The bench therefore closes every digit pattern, clear, auto-clear and ignored-key case with an enter and checks the pulse in the following cycle. A wrong failure count shows up only at the limit, as a lockout that comes one attempt early or late. The bench therefore walks the full mismatch sequence both before and after a new card. A lockout that leaks is caught by entering the correct PIN while locked and checking that no pulse appears.

// File: rtl/pin_pkg.sv
`timescale 1ns/1ps
package pin_pkg;
  localparam int KEY_W   = 4;
  localparam int KEY_D0  = 0;
  localparam int KEY_D1  = 1;
  localparam int KEY_CLR = 2;
  localparam int KEY_ENT = 3;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_D0   = 3'd1,
    CMD_D1   = 3'd2,
    CMD_CLR  = 3'd3,
    CMD_ENT  = 3'd4
  } key_cmd_e;
endpackage

// File: rtl/pin_key_decode.sv
`timescale 1ns/1ps
module pin_key_decode
  import pin_pkg::*;
(
  input  logic             new_card_i,
  input  logic             pin_en_i,
  input  logic             key_stb_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             locked_i,
  output key_cmd_e         cmd_o
);
  logic accept;

  // single key only, and only while entry is allowed
  assign accept = key_stb_i && pin_en_i && !locked_i && !new_card_i && $onehot(key_i);

  always_comb begin
    cmd_o = CMD_NONE;
    if (accept) begin
      unique case (1'b1)
        key_i[KEY_D0]:  cmd_o = CMD_D0;
        key_i[KEY_D1]:  cmd_o = CMD_D1;
        key_i[KEY_CLR]: cmd_o = CMD_CLR;
        key_i[KEY_ENT]: cmd_o = CMD_ENT;
        default:        cmd_o = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pin_entry_reg.sv
`timescale 1ns/1ps
module pin_entry_reg
  import pin_pkg::*;
#(
  parameter int PIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_card_i,
  input  key_cmd_e         cmd_i,
  output logic [PIN_W-1:0] entry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o <= '0;
    end else if (new_card_i) begin
      entry_o <= '0;
    end else begin
      case (cmd_i)
        CMD_D0:  entry_o <= {entry_o[PIN_W-2:0], 1'b0};
        CMD_D1:  entry_o <= {entry_o[PIN_W-2:0], 1'b1};
        CMD_CLR,
        CMD_ENT: entry_o <= '0;  // enter also empties the entry for the next try
        default: entry_o <= entry_o;
      endcase
    end
  end
endmodule

// File: rtl/pin_fail_tracker.sv
`timescale 1ns/1ps
module pin_fail_tracker
  import pin_pkg::*;
#(
  parameter int FAIL_LIMIT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic new_card_i,
  input  logic enter_i,
  input  logic pin_eq_i,
  output logic match_o,
  output logic retry_o,
  output logic lockout_o
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_RETRY = CNT_W'(FAIL_LIMIT - 1);

  logic [CNT_W-1:0] fail_cnt;
  logic             miss;

  assign miss = enter_i && !pin_eq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_cnt  <= '0;
      match_o   <= 1'b0;
      retry_o   <= 1'b0;
      lockout_o <= 1'b0;
    end else if (new_card_i) begin
      fail_cnt  <= '0;
      match_o   <= 1'b0;
      retry_o   <= 1'b0;
      lockout_o <= 1'b0;
    end else begin
      match_o <= enter_i && pin_eq_i;
      retry_o <= miss && (fail_cnt < LAST_RETRY);
      if (miss && !lockout_o) begin
        fail_cnt <= fail_cnt + 1'b1;  // saturates: enter is blocked once locked
        if (fail_cnt == LAST_RETRY) lockout_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pin_checker.sv
`timescale 1ns/1ps
module pin_checker
  import pin_pkg::*;
#(
  parameter int PIN_W      = 4,
  parameter int FAIL_LIMIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_card_i,
  input  logic             pin_en_i,
  input  logic             key_stb_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [PIN_W-1:0] card_pin_i,
  output logic             match_o,
  output logic             retry_o,
  output logic             lockout_o
);
  key_cmd_e         cmd;
  logic [PIN_W-1:0] entry;
  logic             locked;

  pin_key_decode u_dec (
    .new_card_i (new_card_i),
    .pin_en_i   (pin_en_i),
    .key_stb_i  (key_stb_i),
    .key_i      (key_i),
    .locked_i   (locked),
    .cmd_o      (cmd)
  );

  pin_entry_reg #(.PIN_W(PIN_W)) u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .new_card_i (new_card_i),
    .cmd_i      (cmd),
    .entry_o    (entry)
  );

  pin_fail_tracker #(.FAIL_LIMIT(FAIL_LIMIT)) u_fail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .new_card_i (new_card_i),
    .enter_i    (cmd == CMD_ENT),
    .pin_eq_i   (entry == card_pin_i),
    .match_o    (match_o),
    .retry_o    (retry_o),
    .lockout_o  (locked)
  );

  assign lockout_o = locked;
endmodule

// File: rtl/pin_checker_sva.sv
`timescale 1ns/1ps
module pin_checker_sva
  import pin_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             new_card_i,
  input logic             pin_en_i,
  input logic             key_stb_i,
  input logic [KEY_W-1:0] key_i,
  input logic             match_o,
  input logic             retry_o,
  input logic             lockout_o
);
  logic enter_key;
  assign enter_key = key_stb_i && pin_en_i && !new_card_i && (key_i == KEY_W'(1 << KEY_ENT));

  assert_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({match_o, retry_o}) <= 1);

  assert_quiet_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o |-> !match_o && !retry_o);

  assert_match_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(enter_key));

  assert_retry_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(enter_key));

  assert_lock_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lockout_o) |-> $past(enter_key));

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_o && !new_card_i |=> lockout_o);

  assert_new_card_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_card_i |=> !lockout_o && !match_o && !retry_o);

  assert_bad_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$onehot(key_i) |=> !match_o && !retry_o);

  assert_no_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_en_i |=> !match_o && !retry_o);
endmodule

bind pin_checker pin_checker_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .new_card_i (new_card_i),
  .pin_en_i   (pin_en_i),
  .key_stb_i  (key_stb_i),
  .key_i      (key_i),
  .match_o    (match_o),
  .retry_o    (retry_o),
  .lockout_o  (lockout_o)
);

// File: tb/sim_pin_checker.sv
`timescale 1ns/1ps
module sim_pin_checker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       new_card_i = 1'b0;
  logic       pin_en_i = 1'b0;
  logic       key_stb_i = 1'b0;
  logic [3:0] key_i = 4'b0;
  logic [3:0] card_pin_i = 4'b0;
  logic       match_o, retry_o, lockout_o;

  always #2.5 clk_i = ~clk_i;

  pin_checker u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_card_i(new_card_i), .pin_en_i(pin_en_i),
    .key_stb_i(key_stb_i), .key_i(key_i), .card_pin_i(card_pin_i),
    .match_o(match_o), .retry_o(retry_o), .lockout_o(lockout_o)
  );

  typedef struct {
    int    cyc;
    logic  m;
    logic  r;
    logic  l;
    string tag;
  } exp_t;

  exp_t  q[$];
  exp_t  mon_e;
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // reference state, built from the requirements
  logic [3:0] r_entry = 4'b0;
  int         r_fails = 0;
  logic       r_lock = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare each expected item in the cycle it falls due
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      mon_e = q.pop_front();
      n_chk++;
      if ({match_o, retry_o, lockout_o} !== {mon_e.m, mon_e.r, mon_e.l}) begin
        n_bad++;
        $display("FAIL %s: match/retry/lock actual %b%b%b expected %b%b%b",
                 mon_e.tag, match_o, retry_o, lockout_o, mon_e.m, mon_e.r, mon_e.l);
      end
    end
  end

  // driver: one clock per call, called at a falling edge
  task automatic step(input logic nc, input logic en, input logic stb,
                      input logic [3:0] key, input string tag);
    exp_t e;
    logic m = 1'b0;
    logic r = 1'b0;
    new_card_i = nc; pin_en_i = en; key_stb_i = stb; key_i = key;
    if (nc) begin
      r_entry = 4'b0; r_fails = 0; r_lock = 1'b0;
    end else if (en && stb && !r_lock && $countones(key) == 1) begin
      if (key[0]) r_entry = {r_entry[2:0], 1'b0};
      else if (key[1]) r_entry = {r_entry[2:0], 1'b1};
      else if (key[2]) r_entry = 4'b0;
      else begin
        if (r_entry == card_pin_i) m = 1'b1;
        else begin
          r_fails++;
          if (r_fails >= 3) r_lock = 1'b1;
          else r = 1'b1;
        end
        r_entry = 4'b0;
      end
    end
    e.cyc = cyc + 1; e.m = m; e.r = r; e.l = r_lock; e.tag = tag;
    q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic dig(input logic b, input string tag);
    step(1'b0, 1'b1, 1'b1, b ? 4'b0010 : 4'b0001, tag);
  endtask
  task automatic ent(input string tag);
    step(1'b0, 1'b1, 1'b1, 4'b1000, tag);
  endtask
  task automatic clr(input string tag);
    step(1'b0, 1'b1, 1'b1, 4'b0100, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 1'b1, 1'b0, 4'b0000, tag);
  endtask
  task automatic pin4(input logic [3:0] p, input string tag);
    for (int i = 3; i >= 0; i--) dig(p[i], tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, 4'b0, "R1 reset state");

    // R2 full entry, MSB first
    card_pin_i = 4'b1011;
    pin4(4'b1011, "R2 digits"); ent("R5 match");
    idle("R5 one-cycle pulse");
    // R2 short entry pads with leading zeros
    card_pin_i = 4'b0011;
    dig(1'b1, "R2"); dig(1'b1, "R2"); ent("R2 short entry match");
    // R6 wrong PIN
    pin4(4'b0111, "R6 digits"); ent("R6 retry");
    idle("R6 retry one cycle");
    // R4 clear
    card_pin_i = 4'b0010;
    dig(1'b1, "R4"); dig(1'b1, "R4"); dig(1'b1, "R4"); clr("R4 clear");
    dig(1'b1, "R4"); dig(1'b0, "R4"); ent("R4 match after clear");
    // R9 auto-clear after enter
    card_pin_i = 4'b0000;
    dig(1'b1, "R9"); ent("R9 mismatch"); ent("R9 empty entry matches zero");
    // R11 enable low
    card_pin_i = 4'b0000;
    step(1'b0, 1'b0, 1'b1, 4'b0010, "R11 digit ignored");
    step(1'b0, 1'b0, 1'b1, 4'b1000, "R11 enter ignored");
    ent("R11 entry still zero");
    // R3 bad keys
    card_pin_i = 4'b0000;
    step(1'b0, 1'b1, 1'b1, 4'b0000, "R3 no key");
    step(1'b0, 1'b1, 1'b1, 4'b0011, "R3 two digits");
    step(1'b0, 1'b1, 1'b1, 4'b1100, "R3 clear+enter");
    step(1'b0, 1'b1, 1'b0, 4'b0010, "R3 key without strobe");
    step(1'b0, 1'b1, 1'b0, 4'b1000, "R3 enter without strobe");
    ent("R3 entry untouched");

    // R7 lockout on third failure
    card_pin_i = 4'b1010;
    step(1'b1, 1'b1, 1'b0, 4'b0, "R10 new card");
    ent("R7 fail 1"); ent("R7 fail 2"); ent("R7 fail 3 locks");
    idle("R7 lock held"); idle("R7 lock held");
    // R8 keys ignored while locked
    pin4(4'b1010, "R8 digits"); ent("R8 no match while locked");
    ent("R8 no retry while locked");
    // R10 new card with enter in the same cycle
    step(1'b1, 1'b1, 1'b1, 4'b1000, "R10 new card ignores key");
    pin4(4'b1010, "R10 digits"); ent("R10 match after new card");
    ent("R10 count cleared fail 1"); ent("R10 fail 2 still retry");
    ent("R7 fail 3 locks again");
    idle("R7 lock held");
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule